// File: doc/BRIEF.md
# Alternating-Polarity Stepping Motor Pulse Former

This block drives the two coil terminals of a bipolar stepping motor in an analog clock movement. It runs from a 32768 Hz reference clock. Once every motor period it emits one drive pulse of a selected width. During the pulse one drive enable is high and the other is low. The next pulse swaps which enable is high, so the coil current reverses on every step. Outside a pulse both enables stay low.

The normal period and the pulse width are picked by static select inputs. A motor-test request replaces the normal period with a shorter test period so that the gear train can be exercised quickly, and it leaves the pulse width alone. The period length and the width are captured only at a period boundary. A change to the selects or to the test request therefore never cuts a pulse or a period short. All timing comes from one period counter. Its time unit is `UNIT_CYC` reference cycles, which is 256 by default (1/128 s).

Top module: `motor_pulse_former`

## Requirements
- R1: With `test_req` low, the period in units is set by `per_sel`: 0 gives 16 (125 ms), 1 gives 32 (250 ms), 2 gives 64 (500 ms), 3 gives 256 (2 s), and any other value gives 2048 (16 s). One unit is `UNIT_CYC` cycles.
- R2: The pulse width in units is set by `wid_sel`: 0 gives 2 (512 cycles, 15.6 ms), 1 gives 3 (23.4 ms), 2 gives 4 (31.25 ms) and 3 gives 6 (46.9 ms). Only combinations with period ≥ 4 × width or period = 2 × width are legal.
- R3: Consecutive pulses alternate between `mot1` and `mot2`, and the first pulse after reset is on `mot1`.
- R4: Between pulses both outputs are low, and the two outputs are never high together.
- R5: With `test_req` high, the period in units is set by `test_sel`: 0 gives 32 (250 ms), 1 gives 64 (500 ms), and 2 or 3 give 128 (1 s). The pulse width still follows `wid_sel`.
- R6: A change of `test_req`, `test_sel`, `per_sel` or `wid_sel` takes effect only from the next period boundary. The period in progress keeps its length and its pulse width.
- R7: While the synchronous reset `rst` is high, both outputs are low from the first clock edge on. After release, a pulse starts on `mot1` at the first clock edge with `rst` low, and a new period starts every period length after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| test_req | input | 1 | Motor-test request; selects the test period |
| per_sel | input | 3 | Normal period select |
| test_sel | input | 2 | Test period select |
| wid_sel | input | 2 | Pulse width select |
| mot1 | output | 1 | Drive enable, terminal 1 (high during its pulses) |
| mot2 | output | 1 | Drive enable, terminal 2 (high during its pulses) |

## Verification
Both outputs are registered. Count edges from the first rising edge with `rst` low, and call that edge number one. The output after edge t then reflects position (t−1) mod P of period number (t−1) div P. So a pulse becomes visible one edge after its period starts and lasts exactly W cycles. A select change made inside period k first shows at the start of period k+1. The bench samples on the falling edge after every rising edge and compares against these formulas. It sweeps every legal normal and test combination with a small `UNIT_CYC`, and it places mode, width and reset changes in the middle of a pulse.

// File: rtl/motor_pulse_former.sv
module motor_pulse_former #(
  parameter int UNIT_CYC = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       test_req,
  input  logic [2:0] per_sel,
  input  logic [1:0] test_sel,
  input  logic [1:0] wid_sel,
  output logic       mot1,
  output logic       mot2
);

  localparam int MAXCYC = 2048 * UNIT_CYC;
  localparam int CW = $clog2(MAXCYC + 1);
  localparam logic [CW-1:0] UNIT = CW'(UNIT_CYC);

  function automatic logic [11:0] norm_units(input logic [2:0] s);
    case (s)
      3'd0:    return 12'd16;
      3'd1:    return 12'd32;
      3'd2:    return 12'd64;
      3'd3:    return 12'd256;
      default: return 12'd2048;
    endcase
  endfunction

  function automatic logic [11:0] test_units(input logic [1:0] s);
    case (s)
      2'd0:    return 12'd32;
      2'd1:    return 12'd64;
      default: return 12'd128;
    endcase
  endfunction

  function automatic logic [2:0] wid_units(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  logic [CW-1:0] cnt, len;
  logic [2:0]    wu;
  logic          pol;

  wire [11:0]   sel_units = test_req ? test_units(test_sel) : norm_units(per_sel);
  wire [CW-1:0] next_len  = CW'(sel_units) * UNIT;
  wire [CW-1:0] wcyc      = CW'(wu) * UNIT;
  wire          wrap      = (cnt == len - CW'(1));
  wire          on        = (cnt < wcyc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pol  <= 1'b0;
      len  <= next_len;
      wu   <= wid_units(wid_sel);
      mot1 <= 1'b0;
      mot2 <= 1'b0;
    end else begin
      mot1 <= on & ~pol;
      mot2 <= on & pol;
      if (wrap) begin
        cnt <= '0;
        pol <= ~pol;
        len <= next_len;
        wu  <= wid_units(wid_sel);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  logic last_m2;
  always_ff @(posedge clk) begin
    if (rst)       last_m2 <= 1'b1;
    else if (mot2) last_m2 <= 1'b1;
    else if (mot1) last_m2 <= 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!mot1 && !mot2)); // R7
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst) !(mot1 && mot2)); // R4
  AST_ALT_TO_M1: assert property (@(posedge clk) disable iff (rst) $rose(mot1) |-> last_m2); // R3
  AST_ALT_TO_M2: assert property (@(posedge clk) disable iff (rst) $rose(mot2) |-> !last_m2); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt < len); // R1
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(wrap) |-> ($stable(len) && $stable(wu))); // R6
  AST_LEGAL_COMBO: assert property (@(posedge clk) disable iff (rst)
    ({3'b0, len} >= {1'b0, wcyc, 2'b0}) || ({3'b0, len} == {2'b0, wcyc, 1'b0})); // R2

endmodule

// File: tb/test_motor_pulse_former.sv
module test_motor_pulse_former;
  localparam int U = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_req = 1'b0;
  logic [2:0] per_sel = '0;
  logic [1:0] test_sel = '0;
  logic [1:0] wid_sel = '0;
  logic mot1, mot2;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  motor_pulse_former #(.UNIT_CYC(U)) i_motor_pulse_former (
    .clk(clk), .rst(rst), .test_req(test_req), .per_sel(per_sel),
    .test_sel(test_sel), .wid_sel(wid_sel), .mot1(mot1), .mot2(mot2));

  function automatic int norm_p(input int s);
    case (s)
      0: return 16 * U;
      1: return 32 * U;
      2: return 64 * U;
      3: return 256 * U;
      default: return 2048 * U;
    endcase
  endfunction

  function automatic int test_p(input int s);
    case (s)
      0: return 32 * U;
      1: return 64 * U;
      default: return 128 * U;
    endcase
  endfunction

  function automatic int wid_w(input int s);
    case (s)
      0: return 2 * U;
      1: return 3 * U;
      2: return 4 * U;
      default: return 6 * U;
    endcase
  endfunction

  task automatic check(input logic e1, input logic e2, input string tag);
    total++;
    if (mot1 !== e1 || mot2 !== e2) begin
      bad++;
      $display("FAIL %s t=%0t actual mot1=%b mot2=%b expected mot1=%b mot2=%b",
               tag, $time, mot1, mot2, e1, e2);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, tag);
    rst = 1'b0;
  endtask

  // check ncyc cycles of period idx (length P, width W); act at position act_m
  task automatic span(input int P, input int W, input int idx, input int ncyc,
                      input int act_m, input int act, input string tag);
    for (int m = 0; m < ncyc; m++) begin
      @(posedge clk);
      @(negedge clk);
      check((m < W) && (idx % 2 == 0), (m < W) && (idx % 2 == 1), tag);
      if (m == act_m) begin
        case (act)
          1: test_req = 1'b1;
          2: test_req = 1'b0;
          3: wid_sel = 2'd1;
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 R2 R3 R4 R7: all legal normal combinations
    for (int p = 0; p < 5; p++) begin
      for (int w = 0; w < 4; w++) begin
        if (!(norm_p(p) >= 4 * wid_w(w) || norm_p(p) == 2 * wid_w(w))) continue;
        test_req = 1'b0; per_sel = 3'(p); wid_sel = 2'(w);
        do_reset("R7 reset quiet");
        for (int k = 0; k < 3; k++)
          span(norm_p(p), wid_w(w), k, (p == 4 && k == 2) ? 40 : norm_p(p), -1, 0,
               "R1/R2/R3/R4 normal sweep");
      end
    end
    // R5: test periods keep width
    for (int t = 0; t < 4; t++) begin
      for (int w = 0; w < 4; w++) begin
        test_req = 1'b1; test_sel = 2'(t); per_sel = 3'd4; wid_sel = 2'(w);
        do_reset("R7 reset quiet");
        for (int k = 0; k < 3; k++)
          span(test_p(t), wid_w(w), k, test_p(t), -1, 0, "R5 test sweep");
      end
    end
    // R6: mode and width changes apply at the next boundary
    test_req = 1'b0; per_sel = 3'd0; test_sel = 2'd2; wid_sel = 2'd0;
    do_reset("R7 reset quiet");
    span(norm_p(0), wid_w(0), 0, norm_p(0), 1, 1, "R6 test entry mid pulse");
    span(test_p(2), wid_w(0), 1, test_p(2), -1, 0, "R6 test period");
    span(test_p(2), wid_w(0), 2, test_p(2), 2, 2, "R6 test exit mid pulse");
    span(norm_p(0), wid_w(0), 3, norm_p(0), 1, 3, "R6 width change mid pulse");
    span(norm_p(0), wid_w(1), 4, norm_p(0), -1, 0, "R6 new width");
    span(norm_p(0), wid_w(1), 5, norm_p(0), -1, 0, "R6 new width");
    // R7 R3: reset during a mot2 pulse restarts on mot1
    wid_sel = 2'd0;
    do_reset("R7 reset quiet");
    span(norm_p(0), wid_w(0), 0, norm_p(0), -1, 0, "R3 before reset");
    span(norm_p(0), wid_w(0), 1, 2, -1, 0, "R3 mot2 pulse");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1'b0, 1'b0, "R7 outputs cleared mid pulse");
    rst = 1'b0;
    span(norm_p(0), wid_w(0), 0, norm_p(0), -1, 0, "R7/R3 restart on mot1");
    span(norm_p(0), wid_w(0), 1, norm_p(0), -1, 0, "R3 then mot2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule